// File: doc/BRIEF.md
# Limit-Reload Interval Timer

This block is a word-addressed interval timer. A prescaler divides the system clock into fixed-length ticks (one microsecond at the default settings). A counter advances by one on each tick. When the next value would reach a programmable limit, the counter reloads to 1 rather than 0. A reload sets a sticky "limit reached" flag, and that flag drives a level interrupt. Because the counter restarts at 1, dividing the tick rate by N takes a limit of N+1.

Software sees five registers through a simple read/write bus. The limit and counter values sit in a field starting at bit `CNT_LSB`, and the low bits read as zero. The defaults give a 21-bit field in bits 30:10. Setting `CNT_W=22, CNT_LSB=9` with a half-microsecond tick gives a finer-step variant. The limit can be written in two ways: one write restarts the count, and the other changes the limit while the count keeps running. A user mode adds a run/stop control. A system typically places two instances at different interrupt priorities.

Top module: `tick_limit_timer`

## Requirements
- R1: After reset the counter is 1, the limit is 0, the flag and `irq` are low, the run bit reads 1 and the user-mode bit reads 0.
- R2: Outside a limit write, the counter changes at most once every `TICK_DIV` clock cycles, on the cycle the prescaler completes a tick.
- R3: On a tick, if counter+1 is greater than or equal to the effective limit, the counter reloads to 1; otherwise it increments. With a limit of 4 the sequence is 1,2,3,1. A stored limit of 0 acts as 2^`CNT_W`-1. The comparison uses the limit held before any write in the same cycle.
- R4: A reload sets the flag. The flag appears in bit 31 of both the limit word (offset 0) and the counter word (offset 1), and `irq` is high exactly while the flag is set.
- R5: Reading offset 0 (`rd_en` high) clears the flag and `irq` on the next edge. If a reload happens in the same cycle, the flag stays set.
- R6: Writing offset 0 loads `wdata[CNT_LSB +: CNT_W]` as the limit, sets the counter to 1 and restarts the prescaler. No tick is counted in that cycle.
- R7: Writing offset 2 loads the limit from the same field. The counter and prescaler are left untouched.
- R8: Bit 0 at offset 4 selects user mode, and bit 0 at offset 3 is the run bit. In user mode with run at 0, ticks leave the counter unchanged. Outside user mode the run bit has no effect on counting.
- R9: Offsets 0 and 1 read {flag, field at `CNT_LSB`, zeros below}. Offsets 3 and 4 read their bit in bit 0 with all other bits zero. Offsets 2, 5, 6 and 7 read zero. Writes to offsets 1, 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Word offset of the register accessed |
| wr_en | input | 1 | Write strobe for `addr` |
| rd_en | input | 1 | Read strobe; only the read side effect at offset 0 depends on it |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, high while the flag is set |

## Verification
Two events can collide in one cycle: a reload that sets the flag, and a limit read that clears it. The bench provokes this by holding a read of offset 0 on every cycle while a limit of 2 makes each tick a reload. A reference model then predicts, cycle by cycle, that the set wins and that the clear lands only on the cycles in between. A second collision is also driven: an alias write on the same edge as a tick. For that case the model uses the old limit for the comparison.

// File: rtl/tick_limit_timer.sv
module tick_limit_timer #(
  parameter int TICK_DIV = 50,
  parameter int CNT_W    = 21,
  parameter int CNT_LSB  = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [2:0] A_LIMIT = 3'd0, A_COUNT = 3'd1, A_ALIAS = 3'd2,
                         A_RUN = 3'd3, A_CFG = 3'd4;

  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] cnt, lim, eff_lim, wfield;
  logic [CNT_W:0]   cnt_inc;
  logic             reached, run_bit, user_mode;
  logic             tick, wr_lim, wr_alias, counting, wrap, rd_clr;
  logic [30:0]      cnt_word, lim_word;
  logic             unused_wbits;

  assign tick     = (pre == PRE_LAST);
  assign wr_lim   = wr_en && (addr == A_LIMIT);
  assign wr_alias = wr_en && (addr == A_ALIAS);
  assign rd_clr   = rd_en && (addr == A_LIMIT);
  assign wfield   = wdata[CNT_LSB +: CNT_W];
  assign eff_lim  = (lim == '0) ? CNT_MAX : lim;
  assign cnt_inc  = {1'b0, cnt} + 1'b1;
  assign counting = tick && (!user_mode || run_bit) && !wr_lim;
  assign wrap     = counting && (cnt_inc >= {1'b0, eff_lim});
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= CNT_W'(1);
      lim <= '0;
    end else if (wr_lim) begin
      pre <= '0;
      cnt <= CNT_W'(1);
      lim <= wfield;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (wrap)          cnt <= CNT_W'(1);
      else if (counting) cnt <= cnt_inc[CNT_W-1:0];
      if (wr_alias)      lim <= wfield;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reached   <= 1'b0;
      run_bit   <= 1'b1;
      user_mode <= 1'b0;
    end else begin
      if (wrap)        reached <= 1'b1;
      else if (rd_clr) reached <= 1'b0;
      if (wr_en && addr == A_RUN) run_bit   <= wdata[0];
      if (wr_en && addr == A_CFG) user_mode <= wdata[0];
    end
  end

  assign cnt_word = 31'(cnt) << CNT_LSB;
  assign lim_word = 31'(lim) << CNT_LSB;
  assign irq      = reached;

  always_comb begin
    case (addr)
      A_LIMIT: rdata = {reached, lim_word};
      A_COUNT: rdata = {reached, cnt_word};
      A_RUN:   rdata = {31'b0, run_bit};
      A_CFG:   rdata = {31'b0, user_mode};
      default: rdata = '0;
    endcase
  end

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != '0); // R3
  AST_STEP_OR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == CNT_W'(1))); // R3
  AST_FLAG_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cnt == CNT_W'(1))); // R4
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && wrap) |=> irq); // R5
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> (cnt == CNT_W'(1) && pre == '0)); // R6
  AST_ALIAS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_alias && !tick) |=> $stable(cnt)); // R7
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && !run_bit && !wr_lim) |=> $stable(cnt)); // R8
  AST_NO_EARLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_lim) |=> $stable(cnt)); // R2
endmodule

// File: tb/tick_limit_timer_tb.sv
module tick_limit_timer_tb;
  localparam int DIV = 3, W = 6, LSB = 10;
  localparam int MAXV = (1 << W) - 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  int m_pre, m_cnt, m_lim, m_flag, m_run, m_user;

  tick_limit_timer #(.TICK_DIV(DIV), .CNT_W(W), .CNT_LSB(LSB)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  task automatic model_step();
    int tk, eff, en, setf, fld;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 1; m_lim = 0; m_flag = 0; m_run = 1; m_user = 0;
    end else begin
      tk = (m_pre == DIV - 1);
      eff = (m_lim == 0) ? MAXV : m_lim;
      en = (!m_user) || m_run;
      setf = 0;
      fld = (wdata >> LSB) & MAXV;
      if (wr_en && addr == 0) begin
        m_lim = fld; m_cnt = 1; m_pre = 0;
      end else begin
        m_pre = tk ? 0 : m_pre + 1;
        if (tk && en) begin
          if (m_cnt + 1 >= eff) begin m_cnt = 1; setf = 1; end
          else m_cnt = m_cnt + 1;
        end
        if (wr_en && addr == 2) m_lim = fld;
      end
      if (wr_en && addr == 3) m_run = wdata[0];
      if (wr_en && addr == 4) m_user = wdata[0];
      if (setf) m_flag = 1;
      else if (rd_en && addr == 0) m_flag = 0;
    end
  endtask

  task automatic compare();
    logic [31:0] exp;
    case (addr)
      3'd0: exp = (32'(m_flag) << 31) | (32'(m_lim) << LSB);
      3'd1: exp = (32'(m_flag) << 31) | (32'(m_cnt) << LSB);
      3'd3: exp = 32'(m_run);
      3'd4: exp = 32'(m_user);
      default: exp = 32'd0;
    endcase
    vectors++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s rdata@%0d act=%h exp=%h", cur_req, addr, rdata, exp);
    end
    vectors++;
    if (irq !== m_flag[0]) begin
      errors++;
      $display("FAIL %s irq act=%b exp=%b", cur_req, irq, m_flag[0]);
    end
  endtask

  task automatic drive(input string req, input int a, input bit we, input bit re, input int val);
    @(negedge clk);
    cycles++;
    model_step();
    compare();
    cur_req = req;
    addr = 3'(a); wr_en = we; rd_en = re;
    wdata = we ? ((a == 3 || a == 4) ? 32'(val) : (32'(val) << LSB)) : 32'h0;
  endtask

  task automatic idle(input string req, input int a, input int n);
    for (int i = 0; i < n; i++) drive(req, a, 1'b0, 1'b0, 0);
  endtask

  initial begin
    model_step();
    idle("R1", 1, 3);
    @(negedge clk); rst_n = 1'b1;
    for (int a = 0; a < 8; a++) drive("R1", a, 1'b0, 1'b0, 0);
    idle("R2", 1, 12);
    drive("R6", 0, 1'b1, 1'b0, 4);
    idle("R3", 1, 30);
    drive("R4", 0, 1'b0, 1'b0, 0);
    drive("R5", 0, 1'b0, 1'b1, 0);
    idle("R4", 0, 3);
    drive("R6", 0, 1'b1, 1'b0, 2);
    for (int i = 0; i < 20; i++) drive("R5", 0, 1'b0, 1'b1, 0);
    drive("R6", 0, 1'b1, 1'b0, 10);
    idle("R7", 1, 10);
    drive("R7", 2, 1'b1, 1'b0, 20);
    idle("R7", 1, 20);
    drive("R7", 2, 1'b1, 1'b0, 3);
    idle("R3", 1, 10);
    for (int k = 0; k < DIV; k++) begin
      drive("R7", 2, 1'b1, 1'b0, 5 + k);
      idle("R7", 1, 4);
    end
    drive("R8", 3, 1'b1, 1'b0, 0);
    idle("R8", 1, 12);
    drive("R8", 4, 1'b1, 1'b0, 1);
    idle("R8", 1, 15);
    drive("R8", 3, 1'b1, 1'b0, 1);
    idle("R8", 1, 10);
    drive("R8", 4, 1'b1, 1'b0, 0);
    drive("R9", 1, 1'b1, 1'b0, 7);
    for (int a = 5; a < 8; a++) drive("R9", a, 1'b1, 1'b0, 9);
    for (int a = 0; a < 8; a++) drive("R9", a, 1'b0, 1'b0, 0);
    drive("R6", 0, 1'b1, 1'b0, 0);
    idle("R3", 1, MAXV * DIV + 20);
    drive("R5", 0, 1'b0, 1'b1, 0);
    idle("R5", 0, 4);
    drive("R6", 0, 1'b1, 1'b0, 1);
    idle("R3", 1, 10);
    idle("R3", 1, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule